// File: doc/BRIEF.md
# Machine Security Configuration Register

This block holds the three security control bits that steer a physical memory protection unit: a machine-mode lockdown bit, a machine-mode whitelist (default-deny) bit and a rule-lock bypass bit. Software reaches it through a CSR port that carries an address, write data, write and read strobes, and the privilege level of the access. The current bit values go straight out to the permission checker and to the filter that guards writes to the entry configuration registers.

The register is 64 bits wide. A 64-bit hart reaches it through a single address. A 32-bit hart reaches the low word at the same address and the high word at a second address. Only the three low bits exist. The lockdown and whitelist bits can only be set, and they clear only at reset. The bypass bit can be written freely until it is found at 0 while any protection entry reports its lock bit set. After that it is frozen at 0 until reset.

A single summary input tells the block whether any protection entry, enabled or not, has its lock bit set. An access from a mode below machine mode raises an illegal-access flag and leaves the register unchanged. On a 64-bit hart, an access to the unimplemented high-word address does the same.

Top module: `secfg_reg`

## Requirements
- R1: After reset all three control outputs are 0 and a read of address 0x747 returns zero. Reset also clears the bypass lockout, so the bypass bit can be written again.
- R2: The lockdown bit is bit 0. A machine-mode write of 1 to bit 0 at address 0x747 sets it. Later writes of 0 leave it at 1 until reset.
- R3: The whitelist bit is bit 1. It is set-only in the same way as bit 0.
- R4: The bypass bit is bit 2. While no entry lock is reported, a machine-mode write to address 0x747 loads bit 2 of the write data into it. While it is 1, a write of 0 clears it even when entry locks are reported.
- R5: Once the bypass bit is 0 at a clock edge while the entry-lock input is 1, writes to it are ignored and it stays 0 until reset, even after the entry-lock input returns to 0.
- R6: Bits 3 and above always read as zero, and writing them has no effect on bits 0 to 2.
- R7: An access to 0x747 with a privilege other than machine (2'b11) raises `csr_illegal` in the same cycle, returns zero read data and leaves all bits unchanged.
- R8: With XLEN=64, any access to 0x757 raises `csr_illegal` and changes nothing. With XLEN=32, a machine-mode read of 0x757 returns zero without `csr_illegal`, and a write there has no effect.
- R9: Read data reflects the current register value combinationally in the access cycle. A write becomes visible on the outputs after the next rising clock edge.
- R10: With BYPASS_EN=0 the bypass bit reads 0 and `bypass_o` stays 0 whatever is written.
- R11: Accesses to any other address change nothing, return zero and do not raise `csr_illegal`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| csr_addr | input | 12 | CSR address of the access |
| csr_wdata | input | XLEN | Write data |
| csr_we | input | 1 | Write strobe |
| csr_re | input | 1 | Read strobe |
| csr_priv | input | 2 | Privilege of the access, 2'b11 is machine |
| any_entry_locked | input | 1 | High when any protection entry has its lock bit set |
| csr_rdata | output | XLEN | Read data, valid in the access cycle |
| csr_illegal | output | 1 | Illegal access to this register |
| lockdown_o | output | 1 | Machine-mode lockdown bit |
| whitelist_o | output | 1 | Machine-mode default-deny bit |
| bypass_o | output | 1 | Rule-lock bypass bit |

## Verification
The bench targets the bypass lockout. A design that tests the entry-lock input only combinationally would let the bypass bit be set again once the locks drop. A design that freezes the bypass bit too eagerly would refuse to clear it while locks are present. The bench also writes 0 to the sticky bits, which a plain register would clear. It writes all-ones over the reserved bits, which a careless read path would echo back. It sends user- and supervisor-mode writes and high-word accesses, which a decoder that ignored privilege or data width would accept, and it checks that a 32-bit instance with the bypass disabled never drives that bit.

// File: rtl/secfg_pkg.sv
package secfg_pkg;
   localparam int ADDR_W      = 12;
   localparam int PRIV_W      = 2;
   localparam logic [ADDR_W-1:0] CSR_LO_ADDR = 12'h747;
   localparam logic [ADDR_W-1:0] CSR_HI_ADDR = 12'h757;
   localparam logic [PRIV_W-1:0] PRIV_MACHINE = 2'b11;
   localparam int LKD_BIT     = 0;
   localparam int WLT_BIT     = 1;
   localparam int BYP_BIT     = 2;
   localparam int STICKY_CNT  = 2;
   localparam int NUM_FIELDS  = 3;

   typedef struct packed {
      logic bypass;
      logic whitelist;
      logic lockdown;
   } secfg_fields_t;
endpackage

// File: rtl/secfg_decode.sv
module secfg_decode
   import secfg_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [PRIV_W-1:0] priv,
   input  logic              we,
   input  logic              re,
   output logic              wr_lo,
   output logic              rd_lo,
   output logic              illegal
);
   localparam bit HI_IMPL = (XLEN == 32);

   logic hit_lo;
   logic hit_hi;
   logic priv_ok;
   logic hi_bad;
   logic access;

   assign hit_lo  = (addr == CSR_LO_ADDR);
   assign hit_hi  = (addr == CSR_HI_ADDR);
   assign priv_ok = (priv == PRIV_MACHINE);
   assign access  = we | re;

   generate
      if (HI_IMPL) begin : g_hi_word
         assign hi_bad = 1'b0;
      end else begin : g_no_hi_word
         assign hi_bad = hit_hi;
      end
   endgenerate

   assign illegal = access & (hit_lo | hit_hi) & (~priv_ok | hi_bad);
   assign wr_lo   = we & hit_lo & priv_ok;
   assign rd_lo   = re & hit_lo & priv_ok;
endmodule

// File: rtl/secfg_sticky_bit.sv
module secfg_sticky_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic set_req,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q <= 1'b0;
      else if (set_req) q <= 1'b1;
   end
endmodule

// File: rtl/secfg_bypass_ctl.sv
module secfg_bypass_ctl #(
   parameter bit BYPASS_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr,
   input  logic wbit,
   input  logic any_locked,
   output logic q
);
   generate
      if (BYPASS_EN) begin : g_bypass
         logic lockout_q;
         logic freeze_now;
         logic q_r;

         assign freeze_now = ~q_r & any_locked;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) lockout_q <= 1'b0;
            else        lockout_q <= lockout_q | freeze_now;
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                              q_r <= 1'b0;
            else if (wr && !lockout_q && !freeze_now) q_r <= wbit;
         end

         assign q = q_r;
      end else begin : g_no_bypass
         logic unused_bypass_in;
         assign unused_bypass_in = &{1'b0, clk, rst_n, wr, wbit, any_locked};
         assign q = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/secfg_read_mux.sv
module secfg_read_mux
   import secfg_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic            rd_en,
   input  secfg_fields_t   fields,
   output logic [XLEN-1:0] rdata
);
   always_comb begin
      rdata = '0;
      if (rd_en) rdata[NUM_FIELDS-1:0] = fields;
   end
endmodule

// File: rtl/secfg_reg.sv
module secfg_reg
   import secfg_pkg::*;
#(
   parameter int XLEN      = 64,
   parameter bit BYPASS_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] csr_addr,
   input  logic [XLEN-1:0]   csr_wdata,
   input  logic              csr_we,
   input  logic              csr_re,
   input  logic [PRIV_W-1:0] csr_priv,
   input  logic              any_entry_locked,
   output logic [XLEN-1:0]   csr_rdata,
   output logic              csr_illegal,
   output logic              lockdown_o,
   output logic              whitelist_o,
   output logic              bypass_o
);
   generate
      if (!(XLEN == 32 || XLEN == 64)) begin : g_bad_xlen
         $error("secfg_reg: XLEN must be 32 or 64");
      end
      if (BYP_BIT != STICKY_CNT || NUM_FIELDS != STICKY_CNT + 1) begin : g_bad_layout
         $error("secfg_reg: field layout mismatch");
      end
   endgenerate

   logic                  wr_lo;
   logic                  rd_lo;
   logic [STICKY_CNT-1:0] sticky_q;
   logic                  byp_q;
   secfg_fields_t         fields;
   logic                  unused_wdata;

   assign unused_wdata = &{1'b0, csr_wdata[XLEN-1:NUM_FIELDS]};

   secfg_decode #(.XLEN(XLEN)) u_dec (
      .addr    (csr_addr),
      .priv    (csr_priv),
      .we      (csr_we),
      .re      (csr_re),
      .wr_lo   (wr_lo),
      .rd_lo   (rd_lo),
      .illegal (csr_illegal)
   );

   generate
      for (genvar k = 0; k < STICKY_CNT; k++) begin : g_sticky
         secfg_sticky_bit u_bit (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_req (wr_lo & csr_wdata[k]),
            .q       (sticky_q[k])
         );
      end
   endgenerate

   secfg_bypass_ctl #(.BYPASS_EN(BYPASS_EN)) u_byp (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr         (wr_lo),
      .wbit       (csr_wdata[BYP_BIT]),
      .any_locked (any_entry_locked),
      .q          (byp_q)
   );

   assign fields.lockdown  = sticky_q[LKD_BIT];
   assign fields.whitelist = sticky_q[WLT_BIT];
   assign fields.bypass    = byp_q;

   secfg_read_mux #(.XLEN(XLEN)) u_rd (
      .rd_en  (rd_lo),
      .fields (fields),
      .rdata  (csr_rdata)
   );

   assign lockdown_o  = fields.lockdown;
   assign whitelist_o = fields.whitelist;
   assign bypass_o    = fields.bypass;
endmodule

// File: rtl/secfg_reg_chk.sv
module secfg_reg_chk
   import secfg_pkg::*;
#(
   parameter int XLEN      = 64,
   parameter bit BYPASS_EN = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] csr_addr,
   input logic              csr_we,
   input logic [PRIV_W-1:0] csr_priv,
   input logic              any_entry_locked,
   input logic [XLEN-1:0]   csr_rdata,
   input logic              csr_illegal,
   input logic              lockdown_o,
   input logic              whitelist_o,
   input logic              bypass_o
);
   AST_LOCKDOWN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      lockdown_o |=> lockdown_o); // R2

   AST_WHITELIST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      whitelist_o |=> whitelist_o); // R3

   AST_BYPASS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!bypass_o && any_entry_locked) |=> !bypass_o); // R5

   AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      csr_rdata[XLEN-1:NUM_FIELDS] == '0); // R6

   AST_ILLEGAL_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      csr_illegal |=> $stable({lockdown_o, whitelist_o, bypass_o})); // R7

   AST_LOW_PRIV_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_we && csr_priv != PRIV_MACHINE && csr_addr == CSR_LO_ADDR) |-> csr_illegal); // R7

   generate
      if (XLEN == 64) begin : g_hi_chk
         AST_HI_WORD_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
            (csr_we && csr_addr == CSR_HI_ADDR) |-> csr_illegal); // R8
      end
      if (!BYPASS_EN) begin : g_byp_chk
         AST_BYPASS_HARDWIRED: assert property (@(posedge clk) disable iff (!rst_n)
            csr_we |-> !bypass_o); // R10
      end
   endgenerate
endmodule

bind secfg_reg secfg_reg_chk #(.XLEN(XLEN), .BYPASS_EN(BYPASS_EN)) u_chk (
   .clk              (clk),
   .rst_n            (rst_n),
   .csr_addr         (csr_addr),
   .csr_we           (csr_we),
   .csr_priv         (csr_priv),
   .any_entry_locked (any_entry_locked),
   .csr_rdata        (csr_rdata),
   .csr_illegal      (csr_illegal),
   .lockdown_o       (lockdown_o),
   .whitelist_o      (whitelist_o),
   .bypass_o         (bypass_o)
);

// File: tb/sim_secfg_reg.sv
module sim_secfg_reg;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 13;

   typedef struct packed {
      logic [1:0]  priv;
      logic [11:0] addr;
      logic [63:0] wdata;
      logic        locked;
      logic [2:0]  exp_val;
      logic        exp_ill;
   } vec_t;

   localparam vec_t VECS [NVEC] = '{
      '{2'b00, 12'h747, 64'h7,                 1'b0, 3'b000, 1'b1}, // R7 user write
      '{2'b11, 12'h747, 64'h4,                 1'b0, 3'b100, 1'b0}, // R4 set bypass
      '{2'b11, 12'h747, 64'hFFFF_FFFF_FFFF_FFFC, 1'b0, 3'b100, 1'b0}, // R6 reserved ones
      '{2'b11, 12'h747, 64'h0,                 1'b1, 3'b000, 1'b0}, // R4 clear under locks
      '{2'b11, 12'h747, 64'h4,                 1'b1, 3'b000, 1'b0}, // R5 frozen
      '{2'b11, 12'h747, 64'h4,                 1'b0, 3'b000, 1'b0}, // R5 still frozen
      '{2'b11, 12'h747, 64'h1,                 1'b0, 3'b001, 1'b0}, // R2 set lockdown
      '{2'b11, 12'h747, 64'h0,                 1'b0, 3'b001, 1'b0}, // R2 sticky
      '{2'b11, 12'h757, 64'h2,                 1'b0, 3'b001, 1'b1}, // R8 hi word 64
      '{2'b01, 12'h747, 64'h2,                 1'b0, 3'b001, 1'b1}, // R7 supervisor
      '{2'b11, 12'h748, 64'h2,                 1'b0, 3'b001, 1'b0}, // R11 other addr
      '{2'b11, 12'h747, 64'h2,                 1'b0, 3'b011, 1'b0}, // R3 set whitelist
      '{2'b11, 12'h747, 64'h0,                 1'b0, 3'b011, 1'b0}  // R3 sticky
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] csr_addr = '0;
   logic [63:0] csr_wdata = '0;
   logic        csr_we = 1'b0;
   logic        csr_re = 1'b0;
   logic [1:0]  csr_priv = 2'b11;
   logic        any_entry_locked = 1'b0;
   logic [63:0] rdata0;
   logic [31:0] rdata1;
   logic        ill0, ill1, lkd0, lkd1, wlt0, wlt1, byp0, byp1;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   secfg_reg #(.XLEN(64), .BYPASS_EN(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
      .csr_we(csr_we), .csr_re(csr_re), .csr_priv(csr_priv),
      .any_entry_locked(any_entry_locked), .csr_rdata(rdata0),
      .csr_illegal(ill0), .lockdown_o(lkd0), .whitelist_o(wlt0), .bypass_o(byp0)
   );

   secfg_reg #(.XLEN(32), .BYPASS_EN(1'b0)) u1 (
      .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_wdata(csr_wdata[31:0]),
      .csr_we(csr_we), .csr_re(csr_re), .csr_priv(csr_priv),
      .any_entry_locked(any_entry_locked), .csr_rdata(rdata1),
      .csr_illegal(ill1), .lockdown_o(lkd1), .whitelist_o(wlt1), .bypass_o(byp1)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; csr_we = 1'b0; csr_re = 1'b0; any_entry_locked = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      do_reset();
      // R1: reset state
      csr_re = 1'b1; csr_addr = 12'h747; csr_priv = 2'b11;
      #1;
      check("R1 outputs u0", {61'b0, byp0, wlt0, lkd0}, 64'h0);
      check("R1 read u0", rdata0, 64'h0);
      check("R1 outputs u1", {61'b0, byp1, wlt1, lkd1}, 64'h0);

      for (int i = 0; i < NVEC; i++) begin
         @(negedge clk);
         csr_priv = VECS[i].priv; csr_addr = VECS[i].addr; csr_wdata = VECS[i].wdata;
         csr_we = 1'b1; csr_re = 1'b0; any_entry_locked = VECS[i].locked;
         #1;
         check($sformatf("R7/R8/R11 illegal vec %0d", i), {63'b0, ill0}, {63'b0, VECS[i].exp_ill});
         @(negedge clk);
         csr_we = 1'b0; csr_re = 1'b1; csr_addr = 12'h747; csr_priv = 2'b11;
         #1;
         check($sformatf("R2-R6 value vec %0d", i), rdata0, {61'b0, VECS[i].exp_val});
      end

      // R1: reset clears sticky bits and the bypass lockout
      do_reset();
      @(negedge clk);
      csr_priv = 2'b11; csr_addr = 12'h747; csr_wdata = 64'h1; csr_we = 1'b1; csr_re = 1'b1;
      #1;
      // R9: value not yet updated in the write cycle, read shows old value
      check("R9 before edge", {63'b0, lkd0}, 64'h0);
      check("R9 read old value", rdata0, 64'h0);
      @(posedge clk); #1;
      check("R9 after edge", {63'b0, lkd0}, 64'h1);
      check("R9 read new value", rdata0, 64'h1);
      @(negedge clk);
      csr_wdata = 64'h4; csr_we = 1'b1; csr_re = 1'b0;
      @(negedge clk);
      csr_we = 1'b0;
      #1;
      check("R1 bypass writable after reset", {63'b0, byp0}, 64'h1);
      check("R10 bypass hardwired u1", {63'b0, byp1}, 64'h0);

      // R8: 32-bit high word
      @(negedge clk);
      csr_addr = 12'h757; csr_re = 1'b1; csr_we = 1'b1; csr_wdata = 64'h3;
      #1;
      check("R8 u1 hi read zero", {32'b0, rdata1}, 64'h0);
      check("R8 u1 hi not illegal", {63'b0, ill1}, 64'h0);
      check("R8 u0 hi illegal", {63'b0, ill0}, 64'h1);
      @(negedge clk);
      csr_we = 1'b0;
      #1;
      check("R8 u1 hi write no effect", {63'b0, wlt1}, 64'h0);

      // R10: all ones written to 32-bit instance
      @(negedge clk);
      csr_addr = 12'h747; csr_wdata = 64'h7; csr_we = 1'b1; csr_re = 1'b0;
      @(negedge clk);
      csr_we = 1'b0; csr_re = 1'b1;
      #1;
      check("R10 u1 read", {32'b0, rdata1}, 64'h3);
      check("R6 u1 reserved zero", {32'b0, rdata1[31:3]}, 64'h0);

      // R11: read of an unrelated address returns zero
      csr_addr = 12'h300;
      #1;
      check("R11 other addr read", rdata0, 64'h0);
      check("R11 other addr not illegal", {63'b0, ill0}, 64'h0);

      @(negedge clk);
      csr_re = 1'b0;
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 5000);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule